// File: doc/BRIEF.md
# ADC single-pass scan sequencer

This block runs one pass of analog-to-digital conversions over a group of channels chosen by a bit mask, then stops by itself. A pass starts when the start bit in the control register goes to 1. Software can set the bit by a register write, or any of three trigger inputs can set it: two timer event lines and one external event line. Channels are converted in ascending index order. Each result lands in a data register that belongs to that channel alone. At the end of the pass the start bit clears itself, a sticky completion flag is set, and an interrupt is raised if it is enabled. Software can abort a pass by writing 0 to the start bit.

The analog converter sits outside the block and is driven through a small handshake. `sample_o` is high while the input is being sampled. `conv_start_o` is a one-cycle pulse with the channel index on `conv_ch_o`. The converter answers with `conv_done_i` and `conv_result_i`. Only the first conversion of a pass waits the start delay before sampling; each later conversion samples straight away.

Register map (16-bit data):
- Address 0 is the control register. Bit 0 is start, bit 1 is interrupt enable and bit 2 is the completion flag. Bits [8+NUM_CH-1:8] hold the channel group mask.
- Address 1+n is the result of channel n, zero-extended.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 0, every result register reads 0, and `irq_o`, `sample_o` and `conv_start_o` are low.
- R2: While idle, a pass starts on the clock edge that samples one of these, provided the group mask is nonzero: a control write with bit 0 = 1, or a high level on `trig_tmr0_i`, `trig_tmr1_i` or `trig_ext_i`. Bit 0 then reads 1.
- R3: Each `conv_start_o` pulse carries on `conv_ch_o` the next set bit of the group mask. The pass visits the set bits in strictly ascending order and visits no other channel.
- R4: Let E be the edge on which the pass starts. The first `conv_start_o` is high in the cycle after edge E+DELAY_CYC+SAMPLE_CYC. Every later pulse is high SAMPLE_CYC+1 cycles after the edge that accepted the previous `conv_done_i`. `sample_o` is high for exactly the SAMPLE_CYC cycles before each pulse.
- R5: On the edge that samples `conv_done_i`, `conv_result_i` is written to the result register of the channel being converted (address 1+n). No other result register changes.
- R6: On the edge that accepts the last channel's `conv_done_i`, bit 0 clears to 0, bit 2 sets to 1 and the sequencer goes idle.
- R7: `irq_o` is high exactly when bit 2 and bit 1 are both 1. Bit 2 stays set until a control write with bit 2 = 0. A control write with bit 2 = 1 leaves it unchanged.
- R8: A control write with bit 0 = 0 during a pass stops the pass on that edge. Bit 2 is not set, no further `conv_start_o` follows, and a `conv_done_i` that arrives later writes no result register.
- R9: While a pass runs, a control write leaves the group mask unchanged. Trigger pulses are dropped, so no second pass follows.
- R10: A start request made while the group mask is zero is ignored. Bit 0 stays 0 and no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from address) |
| trig_tmr0_i | input | 1 | Timer trigger 0, one-cycle pulse |
| trig_tmr1_i | input | 1 | Timer trigger 1, one-cycle pulse |
| trig_ext_i | input | 1 | External trigger, synchronous pulse |
| sample_o | output | 1 | Converter sampling window |
| conv_start_o | output | 1 | Start one conversion (one-cycle pulse) |
| conv_ch_o | output | IDX_W | Channel being sampled or converted |
| conv_done_i | input | 1 | Converter finished, result valid |
| conv_result_i | input | RES_W | Conversion result |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The bench builds the block with NUM_CH=8, DELAY_CYC=5 and SAMPLE_CYC=3. It uses a converter model that answers 4 cycles after each start. Eight channels make the top channel reachable, where the index step past the last channel would wrap in a 3-bit field. Masks with gaps, single bits and the full range test the ascending walk. The first-conversion delay differs from the sample length, so any timing built on the wrong phase shows up as a cycle offset. The sample length of three leaves room to land a busy write and a trigger inside a pass, and to abort between two conversions.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_SAMPLE, ST_CONV} scan_state_e;

  localparam int unsigned REG_W     = 16;
  localparam int unsigned MASK_LSB  = 8;
  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_IRQEN = 1;
  localparam int unsigned BIT_FLAG  = 2;
endpackage

// File: rtl/adc_scan_cnt.sv
module adc_scan_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_scan_pick.sv
// Lowest set mask bit at or above from_i.
module adc_scan_pick #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [IDX_W:0]    from_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [NUM_CH-1:0] cand;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
    assign cand[g] = mask_i[g] && ((IDX_W+1)'(g) >= from_i);
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_scan_bank.sv
module adc_scan_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [RES_W-1:0]             data_i,
  output logic [NUM_CH-1:0][RES_W-1:0] res_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               res_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))       res_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned RES_W      = 10,
  parameter int unsigned DELAY_CYC  = 6,
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned ADDR_W     = 4,
  localparam int unsigned IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              trig_tmr0_i,
  input  logic              trig_tmr1_i,
  input  logic              trig_ext_i,
  output logic              sample_o,
  output logic              conv_start_o,
  output logic [IDX_W-1:0]  conv_ch_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic              irq_o
);
  localparam int unsigned CNT_MAX = (DELAY_CYC > SAMPLE_CYC) ? DELAY_CYC : SAMPLE_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] SMP_LD = CNT_W'(SAMPLE_CYC - 1);

  scan_state_e       state_q, state_d;
  logic [IDX_W-1:0]  ch_q, ch_d;
  logic              start_q, start_d;
  logic              flag_q, flag_d;
  logic              pend_q, pend_d;
  logic              irq_en_q;
  logic [NUM_CH-1:0] mask_q, mask_nxt, pick_mask;
  logic [IDX_W:0]    pick_from;
  logic              nxt_found;
  logic [IDX_W-1:0]  nxt_idx;
  logic              cnt_load, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  logic              res_we;
  logic [NUM_CH-1:0][RES_W-1:0] res;

  logic ctrl_wr, trig_any, go, abort, flag_clr, idle;
  logic unused_wdata;

  assign idle      = (state_q == ST_IDLE);
  assign ctrl_wr   = reg_we_i && (reg_addr_i == '0);
  assign trig_any  = trig_tmr0_i || trig_tmr1_i || trig_ext_i;
  assign mask_nxt  = (ctrl_wr && idle) ? reg_wdata_i[MASK_LSB +: NUM_CH] : mask_q;
  assign go        = idle && (mask_nxt != '0) &&
                     ((ctrl_wr && reg_wdata_i[BIT_START]) || trig_any);
  assign abort     = !idle && ctrl_wr && !reg_wdata_i[BIT_START];
  assign flag_clr  = ctrl_wr && !reg_wdata_i[BIT_FLAG];
  assign unused_wdata = ^reg_wdata_i;

  assign pick_mask = idle ? mask_nxt : mask_q;
  assign pick_from = idle ? '0 : ({1'b0, ch_q} + 1'b1);

  adc_scan_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_pick (
    .mask_i (pick_mask),
    .from_i (pick_from),
    .found_o(nxt_found),
    .idx_o  (nxt_idx)
  );

  adc_scan_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load),
    .val_i (cnt_val),
    .zero_o(cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    ch_d     = ch_q;
    start_d  = start_q;
    flag_d   = flag_q && !flag_clr;
    pend_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = SMP_LD;
    res_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go) begin
        state_d  = ST_DELAY;
        ch_d     = nxt_idx;
        start_d  = 1'b1;
        cnt_load = 1'b1;
        cnt_val  = DLY_LD;
      end
      ST_DELAY: if (cnt_zero) begin
        state_d  = ST_SAMPLE;
        cnt_load = 1'b1;
      end
      ST_SAMPLE: if (cnt_zero) begin
        state_d = ST_CONV;
        pend_d  = 1'b1;
      end
      ST_CONV: if (conv_done_i) begin
        res_we = 1'b1;
        if (nxt_found) begin
          state_d  = ST_SAMPLE;
          ch_d     = nxt_idx;
          cnt_load = 1'b1;
        end else begin
          state_d = ST_IDLE;
          start_d = 1'b0;
          flag_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d  = ST_IDLE;
      start_d  = 1'b0;
      flag_d   = flag_q && !flag_clr;
      pend_d   = 1'b0;
      cnt_load = 1'b0;
      res_we   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ch_q     <= '0;
      start_q  <= 1'b0;
      flag_q   <= 1'b0;
      pend_q   <= 1'b0;
      irq_en_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      start_q <= start_d;
      flag_q  <= flag_d;
      pend_q  <= pend_d;
      mask_q  <= mask_nxt;
      if (ctrl_wr) irq_en_q <= reg_wdata_i[BIT_IRQEN];
    end
  end

  adc_scan_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .IDX_W(IDX_W)) i_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (res_we),
    .idx_i (ch_q),
    .data_i(conv_result_i),
    .res_o (res)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == '0) begin
      reg_rdata_o[BIT_START]           = start_q;
      reg_rdata_o[BIT_IRQEN]           = irq_en_q;
      reg_rdata_o[BIT_FLAG]            = flag_q;
      reg_rdata_o[MASK_LSB +: NUM_CH]  = mask_q;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (reg_addr_i == ADDR_W'(n + 1)) reg_rdata_o[RES_W-1:0] = res[n];
      end
    end
  end

  assign sample_o     = (state_q == ST_SAMPLE);
  assign conv_start_o = pend_q;
  assign conv_ch_o    = ch_q;
  assign irq_o        = flag_q && irq_en_q;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_o,
  input logic              conv_start_o,
  input logic [IDX_W-1:0]  conv_ch_o,
  input logic              start_q,
  input logic              flag_q,
  input logic [NUM_CH-1:0] mask_q
);
  logic             seen_q;
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (!start_q) begin
      seen_q <= 1'b0;
    end else if (conv_start_o) begin
      seen_q <= 1'b1;
      last_q <= conv_ch_o;
    end
  end

  assert_sample_in_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> start_q);
  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  assert_ch_selected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> mask_q[conv_ch_o]);
  assert_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && seen_q) |-> (conv_ch_o > last_q));
  assert_flag_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $fell(start_q));
  assert_mask_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && $past(start_q)) |-> $stable(mask_q));
  assert_no_empty_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (mask_q != '0));
endmodule

bind adc_scan_seq adc_scan_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_o    (sample_o),
  .conv_start_o(conv_start_o),
  .conv_ch_o   (conv_ch_o),
  .start_q     (start_q),
  .flag_q      (flag_q),
  .mask_q      (mask_q)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NCH = 8;
  localparam int RW  = 10;
  localparam int D   = 5;
  localparam int S   = 3;
  localparam int C   = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        trig_tmr0_i = 1'b0, trig_tmr1_i = 1'b0, trig_ext_i = 1'b0;
  logic        sample_o, conv_start_o, conv_done_i, irq_o;
  logic [2:0]  conv_ch_o;
  logic [RW-1:0] conv_result_i;

  int checks = 0, fails = 0, cyc = 0, pass_id = 0, cc = 0, last_w = 0;
  logic [2:0] cvt_ch = '0;
  logic [RW-1:0] exp_res [NCH];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [RW-1:0] res_of(input int ch, input int p);
    return RW'((ch * 113 + p * 37 + 9) % 1024);
  endfunction

  // converter model: done C cycles after accepting a start
  always @(posedge clk_i) begin
    if (conv_start_o) begin cc <= C; cvt_ch <= conv_ch_o; end
    else if (cc != 0) cc <= cc - 1;
  end
  assign conv_done_i   = (cc == 1);
  assign conv_result_i = res_of(int'(cvt_ch), pass_id);

  adc_scan_seq #(.NUM_CH(NCH), .RES_W(RW), .DELAY_CYC(D), .SAMPLE_CYC(S), .ADDR_W(4)) i_adc_scan_seq (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .trig_tmr0_i, .trig_tmr1_i, .trig_ext_i, .sample_o, .conv_start_o,
    .conv_ch_o, .conv_done_i, .conv_result_i, .irq_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input int a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = d;
    last_w = cyc + 1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic pulse(input int src);
    case (src)
      1: trig_tmr0_i = 1'b1;
      2: trig_tmr1_i = 1'b1;
      default: trig_ext_i = 1'b1;
    endcase
    last_w = cyc + 1;
    @(negedge clk_i);
    trig_tmr0_i = 1'b0; trig_tmr1_i = 1'b0; trig_ext_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr_i = 4'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic check_bank(input string tag);
    logic [15:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(c + 1, v);
      chk(v == {6'b0, exp_res[c]}, tag, int'(v), int'(exp_res[c]));
    end
  endtask

  task automatic idle_check(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      if (conv_start_o) hits++;
      @(negedge clk_i);
    end
    chk(hits == 0, tag, hits, 0);
  endtask

  task automatic wait_start(input int t, input int ch);
    int n = 0, scnt = 0;
    while (!conv_start_o && n < 400) begin
      scnt = sample_o ? scnt + 1 : 0;
      @(negedge clk_i);
      n++;
    end
    chk(cyc == t, "R4 conversion start cycle", cyc, t);
    chk(scnt == S, "R4 sample window length", scnt, S);
    chk(int'(conv_ch_o) == ch, "R3 channel order", int'(conv_ch_o), ch);
  endtask

  // src: 0 software write, 1 timer0, 2 timer1, 3 external
  task automatic run_pass(input logic [7:0] m, input int src, input bit ien, input bit disturb);
    int t, last_t = 0, done_t;
    bit first = 1'b1;
    logic [15:0] v;
    pass_id++;
    if (src == 0) wr(0, {m, 5'b0, 1'b0, ien, 1'b1});  // R2 software start
    else begin
      wr(0, {m, 5'b0, 1'b0, ien, 1'b0});
      pulse(src);                                     // R2 trigger start
    end
    rd(0, v);
    chk(v[0] == 1'b1, "R2 start bit set", int'(v[0]), 1);
    t = last_w + D + S;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        wait_start(t, c);
        last_t = cyc;
        exp_res[c] = res_of(c, pass_id);
        if (disturb && first) begin
          // R9: busy write with other mask, plus a trigger
          reg_we_i = 1'b1; reg_addr_i = '0; reg_wdata_i = {~m, 5'b0, 1'b0, ien, 1'b1};
          trig_tmr1_i = 1'b1;
          @(negedge clk_i);
          reg_we_i = 1'b0; trig_tmr1_i = 1'b0;
        end else begin
          @(negedge clk_i);
        end
        first = 1'b0;
        t = last_t + S + C + 1;
      end
    end
    done_t = last_t + C + 1;
    while (cyc < done_t - 1) @(negedge clk_i);
    rd(0, v);
    chk(v[2:0] == {1'b0, ien, 1'b1}, "R6 still busy before last result", int'(v[2:0]), int'({1'b0, ien, 1'b1}));
    @(negedge clk_i);
    rd(0, v);
    chk(v[0] == 1'b0, "R6 start bit self-clears", int'(v[0]), 0);
    chk(v[2] == 1'b1, "R6 completion flag", int'(v[2]), 1);
    chk(v[15:8] == m, "R9 group mask unchanged", int'(v[15:8]), int'(m));
    chk(irq_o == ien, "R7 irq follows flag and enable", int'(irq_o), int'(ien));
    check_bank("R5 result register contents");
    if (disturb) idle_check(30, "R9 trigger while busy dropped");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'hACE1));
    for (int c = 0; c < NCH; c++) exp_res[c] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(0, v);
    chk(v == 16'h0, "R1 control reset", int'(v), 0);
    chk({irq_o, sample_o, conv_start_o} == 3'b0, "R1 outputs low", int'({irq_o, sample_o, conv_start_o}), 0);
    check_bank("R1 result reset");

    // directed: gapped group, software start
    run_pass(8'hA5, 0, 1'b1, 1'b0);
    // R7 writing 1 to the flag keeps it
    wr(0, {8'hA5, 5'b0, 1'b1, 1'b1, 1'b0});
    rd(0, v);
    chk(v[2] == 1'b1, "R7 flag kept on write 1", int'(v[2]), 1);
    chk(irq_o == 1'b1, "R7 irq held", int'(irq_o), 1);
    wr(0, {8'hA5, 5'b0, 1'b0, 1'b1, 1'b0});
    rd(0, v);
    chk(v[2] == 1'b0, "R7 flag cleared on write 0", int'(v[2]), 0);
    chk(irq_o == 1'b0, "R7 irq drops", int'(irq_o), 0);

    // R2 each trigger source, top channel and edges
    run_pass(8'h80, 1, 1'b0, 1'b0);
    run_pass(8'h01, 2, 1'b1, 1'b0);
    run_pass(8'h3C, 3, 1'b1, 1'b0);
    // R9 disturbance during a pass
    run_pass(8'h66, 1, 1'b1, 1'b1);

    // random passes
    for (int k = 0; k < 10; k++) begin
      logic [7:0] m;
      m = 8'($urandom_range(1, 255));
      run_pass(m, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    // R8 abort between first and second conversion
    pass_id++;
    wr(0, {8'hFF, 5'b0, 1'b0, 1'b1, 1'b1});
    wait_start(last_w + D + S, 0);
    exp_res[0] = res_of(0, pass_id);
    @(negedge clk_i);
    wait_start(cyc + S + C, 1);
    wr(0, {8'hFF, 5'b0, 1'b0, 1'b1, 1'b0});
    idle_check(30, "R8 no conversion after abort");
    rd(0, v);
    chk(v == 16'hFF02, "R8 idle without flag", int'(v), 16'hFF02);
    chk(irq_o == 1'b0, "R8 no irq on abort", int'(irq_o), 0);
    check_bank("R8 late result discarded");

    // R10 empty group
    wr(0, 16'h0003);
    rd(0, v);
    chk(v == 16'h0002, "R10 empty group ignored", int'(v), 2);
    pulse(3);
    idle_check(20, "R10 trigger with empty group");

    summary();
  end
endmodule